// File: doc/BRIEF.md
# Alias-Window Address Decoder with Byte-Lane Reversal

This block sits behind a bus target interface. It decides which internal target claims an access made by a bus master. There are three target groups: memory bank group 0, memory bank group 1 and a device space. Each group has a primary window and an alias window, and both share one size mask. A window is a 4 KB-aligned base on address bits 31:12. The access hits the window when the masked upper address bits equal the masked base. Each window also has its own enable bit, so a window can stay programmed but never answer.

An access that lands in an alias window is carried with the opposite of the global byte-order setting. Software can therefore write a buffer through one range and read it back through the other with every 32-bit word byte-reversed. The block applies the lane reversal itself, both to the master's write data and to the data the target returns. The decode is combinational from the address and the programmed registers. It is registered once, so the result is presented on the clock edge after the address is offered. The registers are read and written through a small configuration port.

Top module: `sad_alias_decoder`

## Requirements
- R1: After reset, the configuration reads back as follows. Primary and alias bases: group 0 = 0x00000000, group 1 = 0x01000000, device = 0x1C000000. All three masks = 0xFF000000. Enable register = 0x07, which enables the primary windows and disables the alias windows. Byte-order control = 0. No decode result is presented.
- R2: A window hits when (addr[31:12] & mask) == (base & mask). Address bits 11:0 never affect the decision.
- R3: A window whose enable bit is 0 never claims an access, even when the address lies inside it. Enable bit g is the primary window of group g (0, 1, 2). Enable bit 3+g is the alias window of group g.
- R4: The decode result appears with dec_valid_o high on exactly the clock after req_valid_i is sampled high, and dec_valid_o is low otherwise.
- R5: dec_sel_o is one-hot or zero. Bit 0 is bank group 0, bit 1 is bank group 1 and bit 2 is the device space. dec_hit_o is high exactly when a bit is set. When no enabled window matches, both are zero.
- R6: When enabled windows of several groups match, the lowest-numbered group claims the access.
- R7: When the primary and alias windows of the same group both match, the access is treated as primary, not as an alias hit, and dec_cfg_err_o is raised.
- R8: For a claimed access, dec_swap_o = control bit 0 XOR (alias-only hit). dec_wdata_o is the write data with byte lanes reversed (lane 0 to lane 3, lane 1 to lane 2) when dec_swap_o is 1, and is unchanged otherwise. On a miss, dec_swap_o is 0.
- R9: mst_rdata_o is tgt_rdata_i, lane-reversed when the most recent decode had its swap flag set.
- R10: Configuration map on cfg_addr_i[3:0]. Addresses 0-2 hold the primary bases, 4-6 the alias bases and 8-10 the masks, for groups 0-2. Address 12 holds the enable bits [5:0]. Address 13 holds the byte-order control in bit 0. Bases and masks read with bits 11:0 as zero. Writes to any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 4 | Configuration register select |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Configuration read data (combinational) |
| req_valid_i | input | 1 | Address phase valid |
| req_addr_i | input | 32 | Master address |
| req_wdata_i | input | 32 | Master write data |
| tgt_rdata_i | input | 32 | Read data from the claimed target |
| dec_valid_o | output | 1 | Decode result valid |
| dec_hit_o | output | 1 | Some target claimed the access |
| dec_sel_o | output | 3 | One-hot target select |
| dec_swap_o | output | 1 | Lane reversal applied to this access |
| dec_cfg_err_o | output | 1 | Primary and alias windows of one group overlap |
| dec_wdata_o | output | 32 | Write data after lane reversal |
| mst_rdata_o | output | 32 | Read data to the master after lane reversal |

## Verification
The bench aims at the cases where the aliasing logic is easiest to get wrong. It hits an alias window while the global byte-order bit is set, where the two reversals must cancel. It makes the primary and alias windows of one group overlap; a design that gave the alias priority would report a swapped transfer and no error. It places an address inside a window that is disabled, and it moves two groups' windows onto the same range. A broken enable or priority path would claim the access or select the wrong group. It also narrows a mask, and it writes to an unmapped register. It sends back-to-back requests, so a decoder with extra or missing register stages would misalign its results against the expected queue.

// File: rtl/sad_pkg.sv
package sad_pkg;
  localparam int unsigned CFG_AW    = 4;
  localparam logic [1:0]  K_BASE_N  = 2'd0;
  localparam logic [1:0]  K_BASE_S  = 2'd1;
  localparam logic [1:0]  K_MASK    = 2'd2;
  localparam logic [1:0]  K_MISC    = 2'd3;
  localparam logic [1:0]  MISC_EN   = 2'd0;
  localparam logic [1:0]  MISC_CTL  = 2'd1;
endpackage

// File: rtl/sad_cfg_regs.sv
module sad_cfg_regs
  import sad_pkg::*;
#(
  parameter int unsigned N_GRP = 3,
  parameter int unsigned AW    = 32,
  parameter int unsigned PW    = 12,
  parameter logic [N_GRP*(AW-PW)-1:0] RST_BASE_N = '0,
  parameter logic [N_GRP*(AW-PW)-1:0] RST_BASE_S = '0,
  parameter logic [N_GRP*(AW-PW)-1:0] RST_MASK   = '0,
  parameter logic [2*N_GRP-1:0]       RST_EN     = '0
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           we_i,
  input  logic [CFG_AW-1:0]              addr_i,
  input  logic [AW-1:0]                  wdata_i,
  output logic [AW-1:0]                  rdata_o,
  output logic [N_GRP-1:0][AW-PW-1:0]    base_n_o,
  output logic [N_GRP-1:0][AW-PW-1:0]    base_s_o,
  output logic [N_GRP-1:0][AW-PW-1:0]    mask_o,
  output logic [2*N_GRP-1:0]             en_o,
  output logic                           ctl_swap_o
);
  localparam int unsigned BW = AW - PW;

  logic [N_GRP-1:0][BW-1:0] base_n_q, base_n_d;
  logic [N_GRP-1:0][BW-1:0] base_s_q, base_s_d;
  logic [N_GRP-1:0][BW-1:0] mask_q, mask_d;
  logic [2*N_GRP-1:0]       en_q, en_d;
  logic                     ctl_q, ctl_d;
  logic [1:0]               kind;
  logic [1:0]               idx;
  logic                     idx_ok;

  assign kind   = addr_i[3:2];
  assign idx    = addr_i[1:0];
  assign idx_ok = (int'(idx) < int'(N_GRP));

  always_comb begin
    base_n_d = base_n_q;
    base_s_d = base_s_q;
    mask_d   = mask_q;
    en_d     = en_q;
    ctl_d    = ctl_q;
    if (we_i) begin
      unique case (kind)
        K_BASE_N: if (idx_ok) base_n_d[idx] = wdata_i[AW-1:PW];
        K_BASE_S: if (idx_ok) base_s_d[idx] = wdata_i[AW-1:PW];
        K_MASK:   if (idx_ok) mask_d[idx]   = wdata_i[AW-1:PW];
        default: begin
          if (idx == MISC_EN)  en_d  = wdata_i[2*N_GRP-1:0];
          if (idx == MISC_CTL) ctl_d = wdata_i[0];
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_n_q <= RST_BASE_N;
      base_s_q <= RST_BASE_S;
      mask_q   <= RST_MASK;
      en_q     <= RST_EN;
      ctl_q    <= 1'b0;
    end else if (we_i) begin
      base_n_q <= base_n_d;
      base_s_q <= base_s_d;
      mask_q   <= mask_d;
      en_q     <= en_d;
      ctl_q    <= ctl_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (kind)
      K_BASE_N: if (idx_ok) rdata_o = {base_n_q[idx], {PW{1'b0}}};
      K_BASE_S: if (idx_ok) rdata_o = {base_s_q[idx], {PW{1'b0}}};
      K_MASK:   if (idx_ok) rdata_o = {mask_q[idx], {PW{1'b0}}};
      default: begin
        if (idx == MISC_EN)  rdata_o = {{(AW-2*N_GRP){1'b0}}, en_q};
        if (idx == MISC_CTL) rdata_o = {{(AW-1){1'b0}}, ctl_q};
      end
    endcase
  end

  assign base_n_o   = base_n_q;
  assign base_s_o   = base_s_q;
  assign mask_o     = mask_q;
  assign en_o       = en_q;
  assign ctl_swap_o = ctl_q;

  // R10: registers move only on a write strobe
  a_r10_hold_without_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(en_q) && $stable(ctl_q) && $stable(mask_q)));
endmodule

// File: rtl/sad_window_match.sv
module sad_window_match #(
  parameter int unsigned BW = 20
) (
  input  logic [BW-1:0] addr_hi_i,
  input  logic [BW-1:0] base_i,
  input  logic [BW-1:0] mask_i,
  input  logic          en_i,
  output logic          hit_o
);
  assign hit_o = en_i && ((addr_hi_i & mask_i) == (base_i & mask_i));
endmodule

// File: rtl/sad_lane_swap.sv
module sad_lane_swap #(
  parameter int unsigned DW = 32
) (
  input  logic [DW-1:0] din_i,
  output logic [DW-1:0] dout_o
);
  localparam int unsigned LANES = DW / 8;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign dout_o[l*8 +: 8] = din_i[(LANES-1-l)*8 +: 8];
  end
endmodule

// File: rtl/sad_alias_decoder.sv
module sad_alias_decoder
  import sad_pkg::*;
#(
  parameter int unsigned N_GRP  = 3,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned PAGE_W = 12,
  parameter int unsigned DATA_W = 32,
  parameter logic [N_GRP*(ADDR_W-PAGE_W)-1:0] RST_BASE_N = 60'h1C000_01000_00000,
  parameter logic [N_GRP*(ADDR_W-PAGE_W)-1:0] RST_BASE_S = 60'h1C000_01000_00000,
  parameter logic [N_GRP*(ADDR_W-PAGE_W)-1:0] RST_MASK   = 60'hFF000_FF000_FF000,
  parameter logic [2*N_GRP-1:0]               RST_EN     = 6'b000111
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cfg_we_i,
  input  logic [CFG_AW-1:0]      cfg_addr_i,
  input  logic [ADDR_W-1:0]      cfg_wdata_i,
  output logic [ADDR_W-1:0]      cfg_rdata_o,
  input  logic                   req_valid_i,
  input  logic [ADDR_W-1:0]      req_addr_i,
  input  logic [DATA_W-1:0]      req_wdata_i,
  input  logic [DATA_W-1:0]      tgt_rdata_i,
  output logic                   dec_valid_o,
  output logic                   dec_hit_o,
  output logic [N_GRP-1:0]       dec_sel_o,
  output logic                   dec_swap_o,
  output logic                   dec_cfg_err_o,
  output logic [DATA_W-1:0]      dec_wdata_o,
  output logic [DATA_W-1:0]      mst_rdata_o
);
  localparam int unsigned BW = ADDR_W - PAGE_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  logic [N_GRP-1:0][BW-1:0] base_n, base_s, mask;
  logic [2*N_GRP-1:0]       en;
  logic                     ctl_swap;

  sad_cfg_regs #(
    .N_GRP(N_GRP), .AW(ADDR_W), .PW(PAGE_W),
    .RST_BASE_N(RST_BASE_N), .RST_BASE_S(RST_BASE_S),
    .RST_MASK(RST_MASK), .RST_EN(RST_EN)
  ) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_n_int),
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .rdata_o(cfg_rdata_o),
    .base_n_o(base_n), .base_s_o(base_s), .mask_o(mask),
    .en_o(en), .ctl_swap_o(ctl_swap)
  );

  logic [BW-1:0]    addr_hi;
  logic [N_GRP-1:0] hit_n, hit_s;
  assign addr_hi = req_addr_i[ADDR_W-1:PAGE_W];

  for (genvar g = 0; g < N_GRP; g++) begin : g_win
    sad_window_match #(.BW(BW)) u_pri (
      .addr_hi_i(addr_hi), .base_i(base_n[g]), .mask_i(mask[g]),
      .en_i(en[g]), .hit_o(hit_n[g])
    );
    sad_window_match #(.BW(BW)) u_ali (
      .addr_hi_i(addr_hi), .base_i(base_s[g]), .mask_i(mask[g]),
      .en_i(en[N_GRP+g]), .hit_o(hit_s[g])
    );
  end

  logic [N_GRP-1:0] sel_d;
  logic             hit_d, alias_only, swap_d, err_d;

  always_comb begin
    sel_d      = '0;
    hit_d      = 1'b0;
    alias_only = 1'b0;
    for (int g = 0; g < int'(N_GRP); g++) begin
      if (!hit_d && (hit_n[g] || hit_s[g])) begin
        sel_d[g]   = 1'b1;
        hit_d      = 1'b1;
        alias_only = hit_s[g] && !hit_n[g];
      end
    end
    swap_d = hit_d && (ctl_swap ^ alias_only);
    err_d  = |(hit_n & hit_s);
  end

  logic [DATA_W-1:0] wdata_rev, rdata_rev, wdata_d;

  sad_lane_swap #(.DW(DATA_W)) u_wswap (.din_i(req_wdata_i), .dout_o(wdata_rev));
  sad_lane_swap #(.DW(DATA_W)) u_rswap (.din_i(tgt_rdata_i), .dout_o(rdata_rev));

  assign wdata_d = swap_d ? wdata_rev : req_wdata_i;

  logic                   valid_q, hit_q, swap_q, err_q, rd_swap_q;
  logic [N_GRP-1:0]       sel_q;
  logic [DATA_W-1:0]      wdata_q;
  logic                   hit_nx, swap_nx, err_nx;
  logic [N_GRP-1:0]       sel_nx;
  logic [DATA_W-1:0]      wdata_nx;

  always_comb begin
    hit_nx   = req_valid_i ? hit_d   : 1'b0;
    sel_nx   = req_valid_i ? sel_d   : '0;
    swap_nx  = req_valid_i ? swap_d  : 1'b0;
    err_nx   = req_valid_i ? err_d   : 1'b0;
    wdata_nx = req_valid_i ? wdata_d : wdata_q;
  end

  always_ff @(posedge clk_i or negedge rst_n_int) begin
    if (!rst_n_int) begin
      valid_q <= 1'b0;
      hit_q   <= 1'b0;
      sel_q   <= '0;
      swap_q  <= 1'b0;
      err_q   <= 1'b0;
      wdata_q <= '0;
    end else begin
      valid_q <= req_valid_i;
      hit_q   <= hit_nx;
      sel_q   <= sel_nx;
      swap_q  <= swap_nx;
      err_q   <= err_nx;
      wdata_q <= wdata_nx;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_int) begin
    if (!rst_n_int)       rd_swap_q <= 1'b0;
    else if (req_valid_i) rd_swap_q <= swap_d;
  end

  assign dec_valid_o   = valid_q;
  assign dec_hit_o     = hit_q;
  assign dec_sel_o     = sel_q;
  assign dec_swap_o    = swap_q;
  assign dec_cfg_err_o = err_q;
  assign dec_wdata_o   = wdata_q;
  assign mst_rdata_o   = rd_swap_q ? rdata_rev : tgt_rdata_i;

  // R4: one-cycle latency, no spurious results
  a_r4_latency: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    req_valid_i |=> dec_valid_o);
  a_r4_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    !req_valid_i |=> !dec_valid_o);
  // R5: select encoding
  a_r5_sel_onehot: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    $onehot0(dec_sel_o));
  a_r5_hit_matches_sel: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    dec_hit_o == ($countones(dec_sel_o) == 1));
  // R7: overlap error only on a claimed access
  a_r7_err_implies_hit: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    dec_cfg_err_o |-> dec_hit_o);
  // R8: no lane reversal on a miss
  a_r8_no_swap_on_miss: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    !dec_hit_o |-> !dec_swap_o);
endmodule

// File: tb/sim_sad_alias_decoder.sv
module sim_sad_alias_decoder;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [3:0]  cfg_addr;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic        req_valid;
  logic [31:0] req_addr, req_wdata, tgt_rdata;
  logic        dec_valid, dec_hit, dec_swap, dec_err;
  logic [2:0]  dec_sel;
  logic [31:0] dec_wdata, mst_rdata;

  always #4 clk = ~clk;

  sad_alias_decoder u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .cfg_rdata_o(cfg_rdata),
    .req_valid_i(req_valid), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .tgt_rdata_i(tgt_rdata),
    .dec_valid_o(dec_valid), .dec_hit_o(dec_hit), .dec_sel_o(dec_sel),
    .dec_swap_o(dec_swap), .dec_cfg_err_o(dec_err),
    .dec_wdata_o(dec_wdata), .mst_rdata_o(mst_rdata)
  );

  typedef struct {
    logic        hit;
    logic [2:0]  sel;
    logic        swap;
    logic        err;
    logic [31:0] wd;
    logic [31:0] addr;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  logic mon_on = 1'b0;
  logic exp_vld = 1'b0;

  logic [19:0] sh_bn [3];
  logic [19:0] sh_bs [3];
  logic [19:0] sh_mk [3];
  logic [5:0]  sh_en;
  logic        sh_ctl;

  function automatic logic [31:0] rev(input logic [31:0] x);
    return {x[7:0], x[15:8], x[23:16], x[31:24]};
  endfunction

  function automatic exp_t model(input logic [31:0] a, input logic [31:0] wd);
    exp_t e;
    logic hn, hs, alias_only;
    e.hit = 1'b0; e.sel = 3'b000; e.swap = 1'b0; e.err = 1'b0; e.addr = a;
    alias_only = 1'b0;
    for (int g = 0; g < 3; g++) begin
      hn = sh_en[g]   && ((a[31:12] & sh_mk[g]) == (sh_bn[g] & sh_mk[g]));
      hs = sh_en[3+g] && ((a[31:12] & sh_mk[g]) == (sh_bs[g] & sh_mk[g]));
      if (hn && hs) e.err = 1'b1;
      if (!e.hit && (hn || hs)) begin
        e.hit = 1'b1;
        e.sel[g] = 1'b1;
        alias_only = hs && !hn;
      end
    end
    e.swap = e.hit && (sh_ctl ^ alias_only);
    e.wd   = e.swap ? rev(wd) : wd;
    return e;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic cfg_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b0;
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    case (a)
      4'd0, 4'd1, 4'd2:  sh_bn[a[1:0]] = d[31:12];
      4'd4, 4'd5, 4'd6:  sh_bs[a[1:0]] = d[31:12];
      4'd8, 4'd9, 4'd10: sh_mk[a[1:0]] = d[31:12];
      4'd12: sh_en  = d[5:0];
      4'd13: sh_ctl = d[0];
      default: ;
    endcase
  endtask

  task automatic cfg_chk(input logic [3:0] a, input logic [31:0] expv, input string tag);
    @(negedge clk);
    req_valid = 1'b0;
    cfg_addr = a;
    #1;
    check(tag, cfg_rdata, expv);
  endtask

  task automatic issue(input logic [31:0] a, input logic [31:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_wdata = wd;
    q.push_back(model(a, wd));
  endtask

  task automatic drain();
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  always @(posedge clk) exp_vld <= req_valid;

  // monitor / scoreboard
  always @(negedge clk) begin
    if (mon_on) begin
      if (exp_vld || dec_valid) check("R4 dec_valid timing", {31'b0, dec_valid}, {31'b0, exp_vld});
      if (dec_valid) begin
        if (q.size() == 0) begin
          check("R4 result without request", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check("R2 R3 R6 hit", {31'b0, dec_hit}, {31'b0, e.hit});
          check("R5 R6 sel", {29'b0, dec_sel}, {29'b0, e.sel});
          check("R7 cfg_err", {31'b0, dec_err}, {31'b0, e.err});
          check("R8 swap", {31'b0, dec_swap}, {31'b0, e.swap});
          check("R8 wdata", dec_wdata, e.wd);
          check("R9 rdata", mst_rdata, e.swap ? rev(tgt_rdata) : tgt_rdata);
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    req_valid = 1'b0; req_addr = '0; req_wdata = '0; tgt_rdata = 32'h11223344;
    sh_bn[0] = 20'h00000; sh_bn[1] = 20'h01000; sh_bn[2] = 20'h1C000;
    sh_bs[0] = 20'h00000; sh_bs[1] = 20'h01000; sh_bs[2] = 20'h1C000;
    for (int g = 0; g < 3; g++) sh_mk[g] = 20'hFF000;
    sh_en = 6'b000111; sh_ctl = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check("R1 no result after reset", {31'b0, dec_valid}, 32'd0);
    cfg_chk(4'd0,  32'h00000000, "R1 base n0");
    cfg_chk(4'd1,  32'h01000000, "R1 base n1");
    cfg_chk(4'd2,  32'h1C000000, "R1 base n2");
    cfg_chk(4'd4,  32'h00000000, "R1 base s0");
    cfg_chk(4'd5,  32'h01000000, "R1 base s1");
    cfg_chk(4'd9,  32'hFF000000, "R1 mask 1");
    cfg_chk(4'd12, 32'h00000007, "R1 enable");
    cfg_chk(4'd13, 32'h00000000, "R1 ctl");
    mon_on = 1'b1;

    // R2 R5: basic primary hits and a miss, back to back
    issue(32'h00000010, 32'hA1B2C3D4);
    issue(32'h01000ABC, 32'h01020304);
    issue(32'h1C000FFC, 32'hDEADBEEF);
    issue(32'h50000000, 32'hCAFEF00D);
    issue(32'h00FFFFFF, 32'h12345678);
    drain();

    // R8 R9: alias window of group 0 at 0x20000000
    cfg_wr(4'd4, 32'h20000123);
    cfg_chk(4'd4, 32'h20000000, "R10 base low bits read zero");
    cfg_wr(4'd12, 32'h0000000F);
    issue(32'h20000400, 32'hA1B2C3D4);
    issue(32'h00000400, 32'hA1B2C3D4);
    drain();

    // R8: global control set, alias cancels it
    cfg_wr(4'd13, 32'h00000001);
    issue(32'h00000040, 32'h55667788);
    issue(32'h20000040, 32'h55667788);
    drain();

    // R7: group 1 alias overlaps its primary
    cfg_wr(4'd12, 32'h0000001F);
    issue(32'h01000000, 32'h0A0B0C0D);
    cfg_wr(4'd13, 32'h00000000);
    issue(32'h01000000, 32'h0A0B0C0D);
    drain();

    // R3: primary of group 0 disabled, address inside it
    cfg_wr(4'd12, 32'h0000001E);
    issue(32'h00000020, 32'h99887766);
    issue(32'h20000020, 32'h99887766);
    drain();

    // R6: group 1 primary moved onto group 0 range
    cfg_wr(4'd12, 32'h00000007);
    cfg_wr(4'd1, 32'h00000000);
    issue(32'h00000800, 32'h13579BDF);
    cfg_wr(4'd12, 32'h00000006);
    issue(32'h00000800, 32'h13579BDF);
    drain();

    // R2: narrower device mask
    cfg_wr(4'd10, 32'hFFFF0000);
    cfg_chk(4'd10, 32'hFFFF0000, "R10 mask readback");
    issue(32'h1C00FFFC, 32'h2468ACE0);
    issue(32'h1C010000, 32'h2468ACE0);
    drain();

    // R10: unmapped writes change nothing
    cfg_wr(4'd3,  32'hFFFFFFFF);
    cfg_wr(4'd11, 32'hFFFFFFFF);
    cfg_wr(4'd15, 32'hFFFFFFFF);
    cfg_chk(4'd12, 32'h00000006, "R10 enable untouched");
    cfg_chk(4'd13, 32'h00000000, "R10 ctl untouched");
    cfg_chk(4'd2,  32'h1C000000, "R10 base n2 untouched");
    issue(32'h1C000000, 32'h0F0E0D0C);
    drain();

    check("R4 all results returned", q.size(), 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule